// File: doc/BRIEF.md
# Dual-Channel Operating-System Timer

This block gives software two timing services that share one input clock. The event channel is a 32-bit up-counter with a compare register. Software arms it for a single deadline. When the count reaches the compare value, the channel raises a flag, and the flag can drive the interrupt line. The free channel is a wide counter that runs without stopping and serves as the system time base. Each channel has its own prescaler, which divides the input clock by 1, 4 or 16. Each channel is also started and stopped through a pair of write-one registers, one that sets enables and one that clears them.

The free counter is wider than the data bus. A read of its low word copies the upper bits into a holding register in the same cycle, so a later read of that holding register completes a coherent snapshot of the whole count. All registers sit on a simple synchronous bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `dual_os_timer`

## Requirements
- R1: After reset, the clock-config register (0x00) reads 0, the enable register (0x34) reads 0, the flag (0x0C) reads 0, the mask (0x10) reads 1, both counters and the high buffer (0x24) read 0, and `irq_o` is 0.
- R2: Writing a 1 to bit 0 or bit 1 at 0x34 enables the event or free channel. Writing a 1 to the same bit at 0x38 disables it. Zero bits have no effect. A read of 0x34 returns the two enable bits.
- R3: Clock-config bits [1:0] select the event prescale and bits [3:2] select the free prescale. Code n advances the counter once every 4^n input clocks, and code 3 acts like code 2 (divide by 16). The prescale phase restarts whenever the channel is disabled or cleared.
- R4: Writing 0x08 with bit 0 set zeroes the event counter, and with bit 1 set zeroes the free counter. Zero bits leave the counters unchanged.
- R5: The enabled event counter (0x18) steps once per prescaled tick up to the compare value (0x14). On the tick that finds the count equal to the compare value, the flag is set and the counter holds.
- R6: Flag bit 0 is cleared by writing 0 to it. Writing 1 does not change it. When a set and a clear fall in the same cycle, the set wins.
- R7: `irq_o` is high exactly when the flag is 1 and mask bit 0 is 0.
- R8: The free counter's low word (0x20) wraps freely. A bus read of 0x20 latches the upper counter bits into the high buffer (0x24). The buffer keeps that value until the next read of 0x20.
- R9: A disabled channel keeps its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; qualifies snapshot capture |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Event interrupt request |

## Verification
A wrong prescale phase shows up at the ports as a counter value that is off by a whole tick after a known number of clocks. A read within 4 to 32 cycles exposes it. A wrong compare or hold path shows up as a flag, and the interrupt that follows from it, that appears one tick early or late. It also shows up as a counter that runs past the compare value, which the next read of 0x18 reveals. A broken snapshot path returns a high word that follows the live counter instead of the value at the last low-word read. The bench provokes this by reading the high word only after the low word has carried across its wrap.

// File: rtl/dos_tmr_pkg.sv
package dos_tmr_pkg;
    localparam int PSC_W  = 2;
    localparam int DIV_W  = 4;
    localparam int NUM_CH = 2;

    localparam logic [7:0] OFF_CLKCFG = 8'h00;
    localparam logic [7:0] OFF_CNTCLR = 8'h08;
    localparam logic [7:0] OFF_FLAG   = 8'h0C;
    localparam logic [7:0] OFF_MASK   = 8'h10;
    localparam logic [7:0] OFF_CMP    = 8'h14;
    localparam logic [7:0] OFF_EVCNT  = 8'h18;
    localparam logic [7:0] OFF_FRLO   = 8'h20;
    localparam logic [7:0] OFF_FRHI   = 8'h24;
    localparam logic [7:0] OFF_ENSET  = 8'h34;
    localparam logic [7:0] OFF_ENCLR  = 8'h38;

    typedef enum logic [PSC_W-1:0] {
        DIV_1   = 2'd0,
        DIV_4   = 2'd1,
        DIV_16  = 2'd2,
        DIV_RSV = 2'd3
    } psc_code_t;

    typedef struct packed {
        logic clkcfg;
        logic cntclr;
        logic flag;
        logic mask;
        logic cmp;
        logic enset;
        logic enclr;
    } wr_sel_t;

    // A tick fires on the last phase of a 4^code period; the reserved code acts like /16.
    function automatic logic psc_hit(psc_code_t code, logic [DIV_W-1:0] div);
        case (code)
            DIV_1:   return 1'b1;
            DIV_4:   return &div[1:0];
            default: return &div;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import dos_tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      restart,
    input  psc_code_t code,
    output logic      tick
);
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !en || restart)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = en && psc_hit(code, div_q);
endmodule

// File: rtl/tmr_event_chan.sv
module tmr_event_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic             flag_wclr,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic hit;
    assign hit = tick && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick && !hit)
            cnt <= cnt + 1'b1;
    end

    // Hardware set has priority over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit && !clr)
            flag <= 1'b1;
        else if (flag_wclr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/tmr_free_chan.sv
module tmr_free_chan #(
    parameter int FR_W = 64,
    parameter int LO_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 clr,
    input  logic                 snap,
    output logic [FR_W-1:0]      cnt,
    output logic [FR_W-LO_W-1:0] hi_buf
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hi_buf <= '0;
        else if (snap)
            hi_buf <= cnt[FR_W-1:LO_W];
    end
endmodule

// File: rtl/dual_os_timer.sv
module dual_os_timer
    import dos_tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int FR_W   = 64,
    parameter int LO_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int HI_W = FR_W - LO_W;

    logic [NUM_CH-1:0][PSC_W-1:0] psc_q;
    logic [NUM_CH-1:0]            en_q;
    logic [NUM_CH-1:0]            clr_ch;
    logic [NUM_CH-1:0]            tick;
    logic                         mask_q;
    logic [DATA_W-1:0]            cmp_q;
    logic [DATA_W-1:0]            ev_cnt;
    logic                         ev_flag;
    logic [FR_W-1:0]              fr_cnt;
    logic [HI_W-1:0]              fr_hi;
    logic                         snap;
    wr_sel_t                      wr;

    function automatic logic at(logic [ADDR_W-1:0] a, logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    always_comb begin
        wr        = '0;
        wr.clkcfg = bus_we && at(bus_addr, OFF_CLKCFG);
        wr.cntclr = bus_we && at(bus_addr, OFF_CNTCLR);
        wr.flag   = bus_we && at(bus_addr, OFF_FLAG);
        wr.mask   = bus_we && at(bus_addr, OFF_MASK);
        wr.cmp    = bus_we && at(bus_addr, OFF_CMP);
        wr.enset  = bus_we && at(bus_addr, OFF_ENSET);
        wr.enclr  = bus_we && at(bus_addr, OFF_ENCLR);
    end

    assign clr_ch = wr.cntclr ? bus_wdata[NUM_CH-1:0] : '0;
    assign snap   = bus_re && at(bus_addr, OFF_FRLO);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q  <= '0;
            en_q   <= '0;
            mask_q <= 1'b1;
            cmp_q  <= '0;
        end else begin
            if (wr.clkcfg) psc_q <= bus_wdata[NUM_CH*PSC_W-1:0];
            if (wr.enset)
                en_q <= en_q | bus_wdata[NUM_CH-1:0];
            else if (wr.enclr)
                en_q <= en_q & ~bus_wdata[NUM_CH-1:0];
            if (wr.mask) mask_q <= bus_wdata[0];
            if (wr.cmp)  cmp_q  <= bus_wdata;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_psc
        tmr_prescaler u_psc (
            .clk     (clk),
            .rst     (rst),
            .en      (en_q[g]),
            .restart (clr_ch[g]),
            .code    (psc_code_t'(psc_q[g])),
            .tick    (tick[g])
        );
    end

    tmr_event_chan #(.CNT_W(DATA_W)) u_ev (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick[0]),
        .clr       (clr_ch[0]),
        .flag_wclr (wr.flag && !bus_wdata[0]),
        .cmp       (cmp_q),
        .cnt       (ev_cnt),
        .flag      (ev_flag)
    );

    tmr_free_chan #(.FR_W(FR_W), .LO_W(LO_W)) u_fr (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick[1]),
        .clr    (clr_ch[1]),
        .snap   (snap),
        .cnt    (fr_cnt),
        .hi_buf (fr_hi)
    );

    always_comb begin
        bus_rdata = '0;
        if      (at(bus_addr, OFF_CLKCFG)) bus_rdata = DATA_W'(psc_q);
        else if (at(bus_addr, OFF_ENSET))  bus_rdata = DATA_W'(en_q);
        else if (at(bus_addr, OFF_FLAG))   bus_rdata = DATA_W'(ev_flag);
        else if (at(bus_addr, OFF_MASK))   bus_rdata = DATA_W'(mask_q);
        else if (at(bus_addr, OFF_CMP))    bus_rdata = cmp_q;
        else if (at(bus_addr, OFF_EVCNT))  bus_rdata = ev_cnt;
        else if (at(bus_addr, OFF_FRLO))   bus_rdata = DATA_W'(fr_cnt[LO_W-1:0]);
        else if (at(bus_addr, OFF_FRHI))   bus_rdata = DATA_W'(fr_hi);
    end

    assign irq_o = ev_flag && !mask_q;
endmodule

// File: rtl/dos_tmr_chk.sv
module dos_tmr_chk
    import dos_tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int FR_W   = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wd0,
    input logic              wd1,
    input logic              irq_o,
    input logic              flag_q,
    input logic              mask_q,
    input logic [1:0]        en_q,
    input logic [DATA_W-1:0] ev_cnt,
    input logic [DATA_W-1:0] cmp_q,
    input logic [FR_W-1:0]   fr_cnt
);
    logic w_enset, w_enclr, w_clr;
    assign w_enset = bus_we && bus_addr == ADDR_W'(OFF_ENSET);
    assign w_enclr = bus_we && bus_addr == ADDR_W'(OFF_ENCLR);
    assign w_clr   = bus_we && bus_addr == ADDR_W'(OFF_CNTCLR);

    p_enset_r2: assert property (@(posedge clk) disable iff (rst)
        (w_enset && wd0) |=> en_q[0]);
    p_enclr_r2: assert property (@(posedge clk) disable iff (rst)
        (w_enclr && wd1) |=> !en_q[1]);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (w_clr && wd1) |=> fr_cnt == '0);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (en_q[0] && ev_cnt == cmp_q && !(w_clr && wd0)) |=> $stable(ev_cnt));
    p_flag_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(en_q[0] && ev_cnt == cmp_q));
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($rose(flag_q) || $fell(mask_q)));
    p_free_step_r8: assert property (@(posedge clk) disable iff (rst)
        (fr_cnt != $past(fr_cnt)) |-> (fr_cnt == FR_W'($past(fr_cnt) + 1'b1) || fr_cnt == '0));
    p_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (!en_q[1] && !(w_clr && wd1)) |=> $stable(fr_cnt));
endmodule

bind dual_os_timer dos_tmr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FR_W(FR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wd0      (bus_wdata[0]),
    .wd1      (bus_wdata[1]),
    .irq_o    (irq_o),
    .flag_q   (ev_flag),
    .mask_q   (mask_q),
    .en_q     (en_q),
    .ev_cnt   (ev_cnt),
    .cmp_q    (cmp_q),
    .fr_cnt   (fr_cnt)
);

// File: tb/sim_dual_os_timer.sv
module sim_dual_os_timer;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int FR_W   = 40;
    localparam int LO_W   = 8;

    localparam logic [7:0] A_CLKCFG = 8'h00, A_CNTCLR = 8'h08, A_FLAG = 8'h0C,
                           A_MASK = 8'h10, A_CMP = 8'h14, A_EVCNT = 8'h18,
                           A_FRLO = 8'h20, A_FRHI = 8'h24, A_ENSET = 8'h34,
                           A_ENCLR = 8'h38;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_os_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FR_W(FR_W), .LO_W(LO_W)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CLKCFG, v); chk("R1 clkcfg", v, 0);
        rd(A_ENSET, v);  chk("R1 enable", v, 0);
        rd(A_FLAG, v);   chk("R1 flag", v, 0);
        rd(A_MASK, v);   chk("R1 mask", v, 1);
        rd(A_EVCNT, v);  chk("R1 evcnt", v, 0);
        rd(A_FRLO, v);   chk("R1 frlo", v, 0);
        rd(A_FRHI, v);   chk("R1 frhi", v, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
    endtask

    task automatic t_enable;
        logic [31:0] v, held;
        wr(A_ENSET, 2); rd(A_ENSET, v); chk("R2 set ch2", v, 2);
        wr(A_ENSET, 0); rd(A_ENSET, v); chk("R2 set zeros", v, 2);
        wr(A_ENSET, 1); rd(A_ENSET, v); chk("R2 set ch1", v, 3);
        wr(A_ENCLR, 0); rd(A_ENCLR + 8'h0, v);
        rd(A_ENSET, v); chk("R2 clr zeros", v, 3);
        wr(A_ENCLR, 1); rd(A_ENSET, v); chk("R2 clr ch1", v, 2);
        wr(A_ENCLR, 2); rd(A_ENSET, v); chk("R2 clr ch2", v, 0);
        wr(A_CNTCLR, 3);
        wr(A_ENSET, 2);
        wait_cyc(10);
        rd(A_FRLO, v); chk("R2 ch2 counting", v, 10);
        wr(A_ENCLR, 2);
        rd(A_FRLO, held); chk("R9 value at stop", held, 12);
        wait_cyc(20);
        rd(A_FRLO, v); chk("R9 held while disabled", v, held);
        rd(A_EVCNT, v); chk("R9 ch1 never enabled long", v, 0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        for (int c = 0; c < 4; c++) begin
            wr(A_CLKCFG, 32'(c) << 2);
            wr(A_ENCLR, 2);
            wr(A_CNTCLR, 2);
            wr(A_ENSET, 2);
            wait_cyc(32);
            rd(A_FRLO, v);
            chk($sformatf("R3 ch2 code %0d", c), v, (c == 0) ? 32 : (c == 1) ? 8 : 2);
        end
        wr(A_ENCLR, 2);
        wr(A_CLKCFG, 32'h1);
        rd(A_CLKCFG, v); chk("R3 clkcfg readback", v, 1);
        wr(A_CMP, 1000);
        wr(A_CNTCLR, 1);
        wr(A_ENSET, 1);
        wait_cyc(16);
        rd(A_EVCNT, v); chk("R3 ch1 div4", v, 4);
        wr(A_ENCLR, 1);
    endtask

    task automatic t_clear;
        logic [31:0] v, held;
        rd(A_FRLO, held);
        wr(A_CNTCLR, 0);
        rd(A_FRLO, v); chk("R4 zero write no effect", v, held);
        rd(A_EVCNT, v); chk("R4 ch1 before clear", v, 4);
        wr(A_CNTCLR, 1);
        rd(A_EVCNT, v); chk("R4 ch1 cleared", v, 0);
        rd(A_FRLO, v); chk("R4 ch2 untouched by bit0", v, held);
        wr(A_CNTCLR, 2);
        rd(A_FRLO, v); chk("R4 ch2 cleared", v, 0);
    endtask

    task automatic t_event;
        logic [31:0] v;
        wr(A_CLKCFG, 0);
        wr(A_FLAG, 0);
        wr(A_CMP, 6);
        wr(A_CNTCLR, 1);
        wr(A_ENSET, 1);
        wr(A_MASK, 0);
        rd(A_EVCNT, v); chk("R5 count after 1 tick", v, 1);
        chk("R7 irq idle", {31'd0, irq_o}, 0);
        wait_cyc(3);
        rd(A_EVCNT, v); chk("R5 count after 5 ticks", v, 5);
        chk("R5 no flag before match tick", {31'd0, irq_o}, 0);
        wait_cyc(1);
        chk("R7 irq on match", {31'd0, irq_o}, 1);
        rd(A_EVCNT, v); chk("R5 count at compare", v, 6);
        wait_cyc(5);
        rd(A_EVCNT, v); chk("R5 count holds", v, 6);
        wr(A_FLAG, 0);
        rd(A_FLAG, v); chk("R6 set beats clear", v, 1);
        wr(A_MASK, 1);
        chk("R7 masked", {31'd0, irq_o}, 0);
        wr(A_MASK, 0);
        chk("R7 unmasked", {31'd0, irq_o}, 1);
        wr(A_ENCLR, 1);
        wr(A_FLAG, 1);
        rd(A_FLAG, v); chk("R6 write one ignored", v, 1);
        wr(A_FLAG, 0);
        rd(A_FLAG, v); chk("R6 write zero clears", v, 0);
        chk("R7 irq after clear", {31'd0, irq_o}, 0);
        rd(A_EVCNT, v); chk("R9 ch1 held when off", v, 6);
    endtask

    task automatic t_snapshot;
        logic [31:0] v;
        wr(A_CNTCLR, 2);
        wr(A_ENSET, 2);
        wait_cyc(510);
        rd(A_FRLO, v); chk("R8 low before wrap", v, 32'hFE);
        wait_cyc(5);
        rd(A_FRHI, v); chk("R8 high frozen at snapshot", v, 1);
        rd(A_FRLO, v); chk("R8 low wrapped", v, 32'h05);
        rd(A_FRHI, v); chk("R8 high new snapshot", v, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_prescale();
        t_clear();
        t_event();
        t_snapshot();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule